// File: doc/BRIEF.md
# Storage Security Mode Controller

This block keeps the security state of a storage device and decides, for each security command the host issues, whether the command executes or is aborted. A command decoder upstream presents a one-cycle strobe with the opcode byte. The controller also receives the 16-bit control word taken from the command's data payload and the result of a password comparison done elsewhere. The controller does not store or compare passwords itself. It only sequences the state that follows from each outcome.

The block tracks five conditions. Four of them are held in one state field: no user password, locked, unlocked and frozen. A fifth condition, erase-prepared, is kept as a flag next to that field. Power-on and hard-reset events are separate one-cycle inputs. Power-on re-locks a device that has a user password. Hard reset only releases the frozen condition. Each accepted command produces a one-cycle `done` pulse and each rejected one produces a one-cycle `abort` pulse, in the cycle after the strobe. A successful erase also produces a one-cycle user-data erase request for the media engine. The stored security level and a packed status byte are always visible.

Top module: `sec_mode_ctrl`

## Requirements
- R1: After `rst_n` is released, `status` is 8'h00, with state code 0 meaning no user password. `abort`, `done`, `erase_req` and `sec_level` are 0.
- R2: The set-password command (opcode F1h) is decoded from the control word. When bit 0 is 0, it enables the user password, moves the state to unlocked (code 2) and stores bit 8 as the level (1 = Maximum, 0 = High). When bit 0 is 1, it sets only the master-present flag and leaves the level unchanged. The command needs no password match.
- R3: In the frozen state (code 3), the following commands abort and change nothing: set password (F1h), unlock (F2h), erase prepare (F3h), erase unit (F4h) and disable password (F6h).
- R4: Freeze lock (F5h) issued while frozen completes with `done`, and the state stays frozen. Only a power-on or hard-reset event leaves the frozen state.
- R5: A hard-reset event returns a frozen state to unlocked if a user password is set, or to no-password if none is set. A hard reset leaves any other lock state as it is and clears erase-prepared. A power-on event sets the state to locked (code 1) if a user password is set, or to no-password otherwise, and clears erase-prepared.
- R6: Erase unit (F4h) is accepted only when the command just before it was erase prepare (F3h). Any other command strobe in between clears erase-prepared, including an opcode outside the security set. An erase unit without erase-prepared set aborts.
- R7: An accepted erase unit with a password match pulses `erase_req` together with `done`. It clears the user password, sets the state to no-password and sets the level to High, and it keeps the master-present flag. An erase unit with a mismatch aborts with no erase request.
- R8: Disable password (F6h) with a match, outside the locked and frozen states, clears the user password, sets the state to no-password and sets the level to High. It keeps the master-present flag. A mismatch aborts.
- R9: Unlock (F2h) with a match moves locked to unlocked. A mismatch aborts and leaves the state unchanged.
- R10: In the locked state, set password (F1h), freeze lock (F5h) and disable password (F6h) abort.
- R11: `abort` and `done` are single-cycle pulses in the cycle after the strobe and never occur together. A command whose strobe coincides with a power-on or hard-reset event is dropped, with neither pulse, and the event decides the new state.
- R12: An opcode outside F1h to F6h raises neither `abort` nor `done`.
- R13: `status` packs the state code in bits [1:0], user-password-enabled in bit 2, master-present in bit 3, erase-prepared in bit 4 and the level in bit 5. Bits 7:6 are 0, and `sec_level` equals bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| por_evt | input | 1 | Power-on event pulse |
| hrst_evt | input | 1 | Hard-reset event pulse |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 8 | Command opcode |
| ctl_word | input | 16 | Control word from the command payload |
| pw_match | input | 1 | Password comparison result for this command |
| abort | output | 1 | Command rejected (one cycle) |
| done | output | 1 | Command accepted (one cycle) |
| erase_req | output | 1 | User-data erase request (one cycle) |
| sec_level | output | 1 | Stored security level (1 = Maximum) |
| status | output | 8 | Packed security status |

## Verification
A wrong internal state shows up on `status` one cycle after the strobe or event that caused it. It also shows up as a wrong pulse on `abort` or `done` for the very next security command, since every command's verdict depends on the state field and the prepared flag. A stale erase-prepared flag can stay hidden until an erase unit arrives. For that reason the prepare, intervening-command and erase sequences are driven back to back and checked on `erase_req` and on bit 4 of `status`. A frozen or locked condition that leaks through a reset event shows up on the first aborted or accepted command after that event.

// File: rtl/sec_pkg.sv
package sec_pkg;
  localparam int OP_W   = 8;
  localparam int CTL_W  = 16;
  localparam int STAT_W = 8;
  localparam int ID_BIT  = 0;
  localparam int LVL_BIT = 8;

  localparam logic [OP_W-1:0] OP_SETPW  = 8'hF1;
  localparam logic [OP_W-1:0] OP_UNLOCK = 8'hF2;
  localparam logic [OP_W-1:0] OP_PREP   = 8'hF3;
  localparam logic [OP_W-1:0] OP_ERASE  = 8'hF4;
  localparam logic [OP_W-1:0] OP_FREEZE = 8'hF5;
  localparam logic [OP_W-1:0] OP_DISPW  = 8'hF6;

  typedef enum logic [1:0] {
    ST_NOPW     = 2'd0,
    ST_LOCKED   = 2'd1,
    ST_UNLOCKED = 2'd2,
    ST_FROZEN   = 2'd3
  } sec_state_e;

  typedef struct packed {
    logic setpw;
    logic unlock;
    logic prep;
    logic erase;
    logic freeze;
    logic dispw;
    logic other;
  } sec_cmd_t;

  typedef struct packed {
    sec_state_e st;
    logic       user_en;
    logic       master_en;
    logic       prepared;
    logic       lvl_max;
  } sec_ctx_t;

  function automatic logic [STAT_W-1:0] pack_status(input sec_ctx_t c);
    logic [STAT_W-1:0] s;
    s = '0;
    s[1:0] = c.st;
    s[2]   = c.user_en;
    s[3]   = c.master_en;
    s[4]   = c.prepared;
    s[5]   = c.lvl_max;
    return s;
  endfunction

  function automatic sec_state_e state_after_hrst(input sec_ctx_t c);
    if (c.st == ST_FROZEN) return c.user_en ? ST_UNLOCKED : ST_NOPW;
    return c.st;
  endfunction

  function automatic sec_state_e state_after_por(input sec_ctx_t c);
    return c.user_en ? ST_LOCKED : ST_NOPW;
  endfunction
endpackage

// File: rtl/sec_decode.sv
module sec_decode
  import sec_pkg::*;
(
  input  logic            cmd_valid,
  input  logic [OP_W-1:0] cmd_op,
  output sec_cmd_t        cmd
);
  logic known;

  always_comb begin
    cmd        = '0;
    cmd.setpw  = cmd_valid && (cmd_op == OP_SETPW);
    cmd.unlock = cmd_valid && (cmd_op == OP_UNLOCK);
    cmd.prep   = cmd_valid && (cmd_op == OP_PREP);
    cmd.erase  = cmd_valid && (cmd_op == OP_ERASE);
    cmd.freeze = cmd_valid && (cmd_op == OP_FREEZE);
    cmd.dispw  = cmd_valid && (cmd_op == OP_DISPW);
    known = cmd.setpw | cmd.unlock | cmd.prep | cmd.erase | cmd.freeze | cmd.dispw;
    cmd.other  = cmd_valid && !known;
  end

  // R11: decoded strobes are mutually exclusive
  always_comb begin
    a_r11_onehot_cmd: assert ($onehot0(cmd))
      else $error("decoder produced more than one command");
  end
endmodule

// File: rtl/sec_policy.sv
module sec_policy
  import sec_pkg::*;
(
  input  sec_ctx_t ctx,
  input  sec_cmd_t cmd,
  input  logic     pw_match,
  input  logic     id_master,
  input  logic     lvl_bit,
  output sec_ctx_t nxt,
  output logic     acc_abort,
  output logic     acc_done,
  output logic     acc_erase
);
  logic frozen, locked;

  assign frozen = (ctx.st == ST_FROZEN);
  assign locked = (ctx.st == ST_LOCKED);

  always_comb begin
    nxt       = ctx;
    acc_abort = 1'b0;
    acc_done  = 1'b0;
    acc_erase = 1'b0;
    if (|cmd) nxt.prepared = 1'b0;

    if (cmd.setpw) begin
      if (frozen || locked) acc_abort = 1'b1;
      else begin
        acc_done = 1'b1;
        if (id_master) nxt.master_en = 1'b1;
        else begin
          nxt.user_en = 1'b1;
          nxt.st      = ST_UNLOCKED;
          nxt.lvl_max = lvl_bit;
        end
      end
    end

    if (cmd.unlock) begin
      if (frozen || !pw_match) acc_abort = 1'b1;
      else begin
        acc_done = 1'b1;
        if (locked) nxt.st = ST_UNLOCKED;
      end
    end

    if (cmd.prep) begin
      if (frozen) acc_abort = 1'b1;
      else begin
        acc_done     = 1'b1;
        nxt.prepared = 1'b1;
      end
    end

    if (cmd.erase) begin
      if (frozen || !ctx.prepared || !pw_match) acc_abort = 1'b1;
      else begin
        acc_done    = 1'b1;
        acc_erase   = 1'b1;
        nxt.user_en = 1'b0;
        nxt.st      = ST_NOPW;
        nxt.lvl_max = 1'b0;
      end
    end

    if (cmd.freeze) begin
      if (locked) acc_abort = 1'b1;
      else begin
        acc_done = 1'b1;
        nxt.st   = ST_FROZEN;
      end
    end

    if (cmd.dispw) begin
      if (frozen || locked || !pw_match) acc_abort = 1'b1;
      else begin
        acc_done    = 1'b1;
        nxt.user_en = 1'b0;
        nxt.st      = ST_NOPW;
        nxt.lvl_max = 1'b0;
      end
    end
  end
endmodule

// File: rtl/sec_state_reg.sv
module sec_state_reg
  import sec_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     por_evt,
  input  logic     hrst_evt,
  input  sec_cmd_t cmd,
  input  logic     pw_match,
  input  sec_ctx_t nxt,
  input  logic     acc_abort,
  input  logic     acc_done,
  input  logic     acc_erase,
  output sec_ctx_t ctx_q,
  output logic     abort_q,
  output logic     done_q,
  output logic     erase_q
);
  logic any_evt;
  assign any_evt = por_evt | hrst_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx_q   <= '0;
      abort_q <= 1'b0;
      done_q  <= 1'b0;
      erase_q <= 1'b0;
    end else if (por_evt) begin
      ctx_q.st       <= state_after_por(ctx_q);
      ctx_q.prepared <= 1'b0;
      abort_q <= 1'b0;
      done_q  <= 1'b0;
      erase_q <= 1'b0;
    end else if (hrst_evt) begin
      ctx_q.st       <= state_after_hrst(ctx_q);
      ctx_q.prepared <= 1'b0;
      abort_q <= 1'b0;
      done_q  <= 1'b0;
      erase_q <= 1'b0;
    end else begin
      ctx_q   <= nxt;
      abort_q <= acc_abort;
      done_q  <= acc_done;
      erase_q <= acc_erase;
    end
  end

  // R3: frozen rejects every lock-changing command
  a_r3_frozen_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_q.st == ST_FROZEN && !any_evt &&
     (cmd.setpw || cmd.unlock || cmd.prep || cmd.erase || cmd.dispw))
    |=> (abort_q && ctx_q.st == ST_FROZEN));

  // R4: frozen persists without a reset event
  a_r4_frozen_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_q.st == ST_FROZEN && !any_evt) |=> (ctx_q.st == ST_FROZEN));

  // R6: an erase request only follows a prepared condition
  a_r6_erase_needs_prep: assert property (@(posedge clk) disable iff (!rst_n)
    erase_q |-> $past(ctx_q.prepared));

  // R7: master flag is never dropped by commands or events
  a_r7_master_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_q.master_en |=> ctx_q.master_en);

  // R9: unlock mismatch from locked keeps the lock
  a_r9_unlock_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_q.st == ST_LOCKED && cmd.unlock && !pw_match && !any_evt)
    |=> (abort_q && ctx_q.st == ST_LOCKED));

  // R11: verdict pulses are exclusive
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort_q && done_q));

  // R11: a command coinciding with an event produces no verdict
  a_r11_event_drop: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> (!abort_q && !done_q && !erase_q));
endmodule

// File: rtl/sec_mode_ctrl.sv
module sec_mode_ctrl
  import sec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_evt,
  input  logic              hrst_evt,
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [CTL_W-1:0]  ctl_word,
  input  logic              pw_match,
  output logic              abort,
  output logic              done,
  output logic              erase_req,
  output logic              sec_level,
  output logic [STAT_W-1:0] status
);
  sec_cmd_t cmd_w;
  sec_ctx_t ctx_w, nxt_w;
  logic     acc_abort_w, acc_done_w, acc_erase_w;

  sec_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd       (cmd_w)
  );

  sec_policy u_pol (
    .ctx       (ctx_w),
    .cmd       (cmd_w),
    .pw_match  (pw_match),
    .id_master (ctl_word[ID_BIT]),
    .lvl_bit   (ctl_word[LVL_BIT]),
    .nxt       (nxt_w),
    .acc_abort (acc_abort_w),
    .acc_done  (acc_done_w),
    .acc_erase (acc_erase_w)
  );

  sec_state_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_evt   (por_evt),
    .hrst_evt  (hrst_evt),
    .cmd       (cmd_w),
    .pw_match  (pw_match),
    .nxt       (nxt_w),
    .acc_abort (acc_abort_w),
    .acc_done  (acc_done_w),
    .acc_erase (acc_erase_w),
    .ctx_q     (ctx_w),
    .abort_q   (abort),
    .done_q    (done),
    .erase_q   (erase_req)
  );

  assign status    = pack_status(ctx_w);
  assign sec_level = ctx_w.lvl_max;

  // R13: level output tracks the packed status
  a_r13_level_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    sec_level == status[5]);
endmodule

// File: tb/sim_sec_mode_ctrl.sv
module sim_sec_mode_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_evt = 1'b0, hrst_evt = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_op = 8'h00;
  logic [15:0] ctl_word = 16'h0000;
  logic pw_match = 1'b0;
  logic abort, done, erase_req, sec_level;
  logic [7:0] status;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_mode_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .hrst_evt(hrst_evt),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .ctl_word(ctl_word),
    .pw_match(pw_match), .abort(abort), .done(done), .erase_req(erase_req),
    .sec_level(sec_level), .status(status)
  );

  // State codes: 0 none, 1 locked, 2 unlocked, 3 frozen
  function automatic logic [7:0] st_word(input int code, input bit u, input bit m,
                                         input bit p, input bit l);
    return {2'b00, l, p, m, u, code[1:0]};
  endfunction

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Compare {abort,done,erase_req,status}
  task automatic expect_out(input string req, input bit ab, input bit dn, input bit er,
                            input logic [7:0] st);
    check(req, {abort, done, erase_req, status}, {ab, dn, er, st});
    if (sec_level !== status[5]) begin
      failures++;
      $display("FAIL R13 sec_level actual=%b expected=%b", sec_level, status[5]);
    end
    checks++;
  endtask

  task automatic issue(input logic [7:0] op, input logic [15:0] ctl, input bit m);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; ctl_word = ctl; pw_match = m;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 8'h00; ctl_word = '0; pw_match = 1'b0;
  endtask

  task automatic pulse_por;
    @(negedge clk); por_evt = 1'b1;
    @(negedge clk); por_evt = 1'b0;
  endtask

  task automatic pulse_hrst;
    @(negedge clk); hrst_evt = 1'b1;
    @(negedge clk); hrst_evt = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1 reset", 0, 0, 0, 8'h00);
  endtask

  task automatic t_nonsec;
    issue(8'hEC, 16'h0000, 1);
    expect_out("R12 foreign opcode", 0, 0, 0, 8'h00);
  endtask

  task automatic t_setpw;
    issue(8'hF1, 16'h0100, 0);
    expect_out("R2 user set max", 0, 1, 0, st_word(2, 1, 0, 0, 1));
    issue(8'hF1, 16'h0001, 0);
    expect_out("R2 master set", 0, 1, 0, st_word(2, 1, 1, 0, 1));
    @(negedge clk);
    expect_out("R11 single pulse", 0, 0, 0, st_word(2, 1, 1, 0, 1));
  endtask

  task automatic t_locked;
    pulse_por;
    expect_out("R5 por locks", 0, 0, 0, st_word(1, 1, 1, 0, 1));
    issue(8'hF1, 16'h0000, 1);
    expect_out("R10 locked setpw", 1, 0, 0, st_word(1, 1, 1, 0, 1));
    issue(8'hF5, 16'h0000, 1);
    expect_out("R10 locked freeze", 1, 0, 0, st_word(1, 1, 1, 0, 1));
    issue(8'hF6, 16'h0000, 1);
    expect_out("R10 locked disable", 1, 0, 0, st_word(1, 1, 1, 0, 1));
    issue(8'hF2, 16'h0000, 0);
    expect_out("R9 unlock mismatch", 1, 0, 0, st_word(1, 1, 1, 0, 1));
    issue(8'hF2, 16'h0000, 1);
    expect_out("R9 unlock match", 0, 1, 0, st_word(2, 1, 1, 0, 1));
  endtask

  task automatic t_frozen;
    logic [7:0] ops [5] = '{8'hF1, 8'hF2, 8'hF3, 8'hF4, 8'hF6};
    issue(8'hF5, 16'h0000, 0);
    expect_out("R4 freeze", 0, 1, 0, st_word(3, 1, 1, 0, 1));
    for (int i = 0; i < 5; i++) begin
      issue(ops[i], 16'h0000, 1);
      expect_out($sformatf("R3 frozen op %h", ops[i]), 1, 0, 0, st_word(3, 1, 1, 0, 1));
    end
    issue(8'hF5, 16'h0000, 0);
    expect_out("R4 freeze again", 0, 1, 0, st_word(3, 1, 1, 0, 1));
    pulse_hrst;
    expect_out("R5 hrst unfreeze", 0, 0, 0, st_word(2, 1, 1, 0, 1));
  endtask

  task automatic t_erase;
    issue(8'hF4, 16'h0000, 1);
    expect_out("R6 erase no prep", 1, 0, 0, st_word(2, 1, 1, 0, 1));
    issue(8'hF3, 16'h0000, 0);
    expect_out("R6 prep", 0, 1, 0, st_word(2, 1, 1, 1, 1));
    issue(8'hEC, 16'h0000, 0);
    expect_out("R6 foreign clears prep", 0, 0, 0, st_word(2, 1, 1, 0, 1));
    issue(8'hF4, 16'h0000, 1);
    expect_out("R6 erase after gap", 1, 0, 0, st_word(2, 1, 1, 0, 1));
    issue(8'hF3, 16'h0000, 0);
    pulse_hrst;
    expect_out("R5 hrst clears prep", 0, 0, 0, st_word(2, 1, 1, 0, 1));
    issue(8'hF3, 16'h0000, 0);
    issue(8'hF4, 16'h0000, 0);
    expect_out("R7 erase mismatch", 1, 0, 0, st_word(2, 1, 1, 0, 1));
    issue(8'hF3, 16'h0000, 0);
    issue(8'hF4, 16'h0000, 1);
    expect_out("R7 erase match", 0, 1, 1, st_word(0, 0, 1, 0, 0));
  endtask

  task automatic t_disable;
    issue(8'hF1, 16'h0000, 0);
    expect_out("R2 user set high", 0, 1, 0, st_word(2, 1, 1, 0, 0));
    issue(8'hF6, 16'h0000, 0);
    expect_out("R8 disable mismatch", 1, 0, 0, st_word(2, 1, 1, 0, 0));
    issue(8'hF1, 16'h0100, 0);
    issue(8'hF6, 16'h0000, 1);
    expect_out("R8 disable match", 0, 1, 0, st_word(0, 0, 1, 0, 0));
    pulse_por;
    expect_out("R5 por no user", 0, 0, 0, st_word(0, 0, 1, 0, 0));
  endtask

  task automatic t_events;
    issue(8'hF1, 16'h0000, 0);
    issue(8'hF5, 16'h0000, 0);
    expect_out("R4 freeze with user", 0, 1, 0, st_word(3, 1, 1, 0, 0));
    pulse_por;
    expect_out("R5 por from frozen", 0, 0, 0, st_word(1, 1, 1, 0, 0));
    pulse_hrst;
    expect_out("R5 hrst keeps lock", 0, 0, 0, st_word(1, 1, 1, 0, 0));
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 8'hF2; pw_match = 1'b1; hrst_evt = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 8'h00; pw_match = 1'b0; hrst_evt = 1'b0;
    expect_out("R11 event drops cmd", 0, 0, 0, st_word(1, 1, 1, 0, 0));
  endtask

  initial begin
    t_reset;
    t_nonsec;
    t_setpw;
    t_locked;
    t_frozen;
    t_erase;
    t_disable;
    t_events;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule